// File: doc/BRIEF.md
# GPIO Interrupt-on-Change Detector

This block watches an 8-bit input port and raises an interrupt when an enabled pin changes state or departs from a stored reference value. It sits behind an input synchronizer and beside a register file that holds its per-pin configuration. The serial link that carries register accesses lives elsewhere; this block only sees the configuration values and two one-cycle read strobes, one for the live port and one for the snapshot.

Each pin has an enable bit and a mode bit. In change mode the pin triggers whenever its level differs from the level seen on the previous clock; edge filtering (rising, falling, both) is left to software, which compares the captured level. In compare mode the pin triggers for as long as it differs from its reference bit, so a reference of 0 gives a level-high trigger and 1 a level-low trigger. When an interrupt is taken, the block records which pins caused it and snapshots the whole port, then holds both until software clears the interrupt with the selected read.

The interrupt pin can be push-pull with selectable polarity, or open-drain, modelled as an output enable and a data line that is low whenever enabled.

Top module: `gpio_ioc_detector`

## Requirements
- R1: After a synchronous active-low reset, and while reset is held, no interrupt is pending, `flags_o` is 0 and `snap_o` is 0; releasing reset with steady nonzero pins raises no interrupt.
- R2: A pin whose `irq_en_i` bit is 0 never causes an interrupt and never appears in `flags_o`.
- R3: With `cmp_mode_i` bit 0, a level change on an enabled pin makes the interrupt pending on the next rising clock edge, with that pin's bit set in `flags_o` and `snap_o` equal to the port value seen at that edge; `flags_o` is nonzero exactly while an interrupt is pending.
- R4: With `cmp_mode_i` bit 1, an enabled pin triggers when its level differs from its `ref_val_i` bit, and does not trigger while they match.
- R5: While an interrupt is pending, `flags_o` and `snap_o` hold their values regardless of further pin activity.
- R6: With `clr_on_cap_i` = 0, a `rd_port_i` pulse clears the pending interrupt and `flags_o` on the next edge; a `rd_cap_i` pulse has no effect.
- R7: With `clr_on_cap_i` = 1, a `rd_cap_i` pulse clears the pending interrupt; a `rd_port_i` pulse has no effect.
- R8: In compare mode, a mismatch that persists through the clear makes the interrupt pending again one clock after the clear; `snap_o` keeps its value across a clear.
- R9: With `open_drain_i` = 0, `irq_oe_o` is 1 and `irq_o` equals the pending state when `act_high_i` = 1 and its inverse when `act_high_i` = 0.
- R10: With `open_drain_i` = 1, `irq_oe_o` equals the pending state and `irq_o` is 0, whatever `act_high_i` is.
- R11: In change mode, a change that occurred while an interrupt was pending and whose new level is steady does not raise a fresh interrupt after the clear.
- R12: Several enabled pins changing on the same clock are all flagged in one interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 8 | Synchronized port pins |
| irq_en_i | input | 8 | Per-pin interrupt enable |
| cmp_mode_i | input | 8 | Per-pin mode: 0 change, 1 compare to reference |
| ref_val_i | input | 8 | Per-pin reference level for compare mode |
| clr_on_cap_i | input | 1 | 0: port read clears, 1: snapshot read clears |
| act_high_i | input | 1 | Push-pull polarity: 1 active high, 0 active low |
| open_drain_i | input | 1 | 1 selects open-drain drive |
| rd_port_i | input | 1 | One-cycle strobe: port register is read |
| rd_cap_i | input | 1 | One-cycle strobe: snapshot register is read |
| flags_o | output | 8 | Pins that caused the pending interrupt |
| snap_o | output | 8 | Port value captured when the interrupt was taken |
| irq_o | output | 1 | Interrupt data level |
| irq_oe_o | output | 1 | Interrupt output enable |

## Verification
The hardest state to reach is a pending interrupt that is cleared while a condition that could retrigger it is still present: a held compare mismatch must fire again a cycle later, while a steady changed level in change mode must not. The stimulus table drives the pins into a pending interrupt, keeps moving them while pending, then issues the clearing read with the pins held, and checks both the cycle of the clear and the cycle after. Clear-source selection is exercised by sending the non-selected read strobe first while an interrupt is pending.

// File: rtl/ioc_pkg.sv
// Shared types for the interrupt-on-change detector.
package ioc_pkg;
    localparam int PORT_W_DEF = 8;

    // Which register read releases a pending interrupt.
    typedef enum logic {
        CLR_BY_PORT = 1'b0,
        CLR_BY_SNAP = 1'b1
    } clr_src_e;
endpackage

// File: rtl/ioc_pin_detect.sv
// Per-pin trigger detection.
// Assumes pin_i is already synchronized to clk. The previous-level register
// follows the pins on every clock, including during reset, so leaving reset
// with steady pins produces no change event.
module ioc_pin_detect #(
    parameter int W = ioc_pkg::PORT_W_DEF
) (
    input  logic         clk,
    input  logic [W-1:0] pin_i,
    input  logic [W-1:0] en_i,
    input  logic [W-1:0] mode_i,
    input  logic [W-1:0] ref_i,
    output logic [W-1:0] trig_o
);
    logic [W-1:0] prev_q;

    // Track last clock's pin levels for change detection.
    always_ff @(posedge clk) begin
        prev_q <= pin_i;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic diff_prev;
        logic diff_ref;
        assign diff_prev = pin_i[i] ^ prev_q[i];
        assign diff_ref  = pin_i[i] ^ ref_i[i];
        // Select the trigger source for this pin and gate it with its enable.
        always_comb begin
            trig_o[i] = en_i[i] & (mode_i[i] ? diff_ref : diff_prev);
        end
    end
endmodule

// File: rtl/ioc_capture.sv
// Pending state, cause flags and port snapshot.
// Assumes read strobes last one cycle. A clear wins over a trigger in the
// same cycle; a trigger arriving while pending is not recorded.
module ioc_capture #(
    parameter int W = ioc_pkg::PORT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     trig_i,
    input  logic [W-1:0]     pin_i,
    input  ioc_pkg::clr_src_e clr_src_i,
    input  logic             rd_port_i,
    input  logic             rd_snap_i,
    output logic             pend_o,
    output logic [W-1:0]     flags_o,
    output logic [W-1:0]     snap_o
);
    logic clr_hit;

    // Decode which read strobe is the active clear.
    always_comb begin
        clr_hit = (clr_src_i == ioc_pkg::CLR_BY_SNAP) ? rd_snap_i : rd_port_i;
    end

    // Take, hold and release the interrupt record.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_o  <= 1'b0;
            flags_o <= '0;
            snap_o  <= '0;
        end else if (pend_o && clr_hit) begin
            pend_o  <= 1'b0;
            flags_o <= '0;
        end else if (!pend_o && (|trig_i)) begin
            pend_o  <= 1'b1;
            flags_o <= trig_i;
            snap_o  <= pin_i;
        end
    end
endmodule

// File: rtl/ioc_irq_drive.sv
// Interrupt pin stage: push-pull with polarity, or open-drain as an
// output enable plus a data line that is low whenever enabled.
module ioc_irq_drive (
    input  logic pend_i,
    input  logic act_high_i,
    input  logic open_drain_i,
    output logic irq_o,
    output logic irq_oe_o
);
    // Map pending state onto the selected drive type.
    always_comb begin
        if (open_drain_i) begin
            irq_oe_o = pend_i;
            irq_o    = 1'b0;
        end else begin
            irq_oe_o = 1'b1;
            irq_o    = act_high_i ? pend_i : ~pend_i;
        end
    end
endmodule

// File: rtl/gpio_ioc_detector.sv
// Top level of the interrupt-on-change detector. Assumes all inputs are
// synchronous to clk. Outputs flags_o/snap_o are registered; the interrupt
// pin is a combinational function of the registered pending bit.
module gpio_ioc_detector #(
    parameter int W = ioc_pkg::PORT_W_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    input  logic [W-1:0] irq_en_i,
    input  logic [W-1:0] cmp_mode_i,
    input  logic [W-1:0] ref_val_i,
    input  logic         clr_on_cap_i,
    input  logic         act_high_i,
    input  logic         open_drain_i,
    input  logic         rd_port_i,
    input  logic         rd_cap_i,
    output logic [W-1:0] flags_o,
    output logic [W-1:0] snap_o,
    output logic         irq_o,
    output logic         irq_oe_o
);
    logic [W-1:0] trig;
    logic         pend;

    ioc_pin_detect #(.W(W)) u_detect (
        .clk    (clk),
        .pin_i  (pin_i),
        .en_i   (irq_en_i),
        .mode_i (cmp_mode_i),
        .ref_i  (ref_val_i),
        .trig_o (trig)
    );

    ioc_capture #(.W(W)) u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_i    (trig),
        .pin_i     (pin_i),
        .clr_src_i (ioc_pkg::clr_src_e'(clr_on_cap_i)),
        .rd_port_i (rd_port_i),
        .rd_snap_i (rd_cap_i),
        .pend_o    (pend),
        .flags_o   (flags_o),
        .snap_o    (snap_o)
    );

    ioc_irq_drive u_drive (
        .pend_i       (pend),
        .act_high_i   (act_high_i),
        .open_drain_i (open_drain_i),
        .irq_o        (irq_o),
        .irq_oe_o     (irq_oe_o)
    );
endmodule

// File: rtl/gpio_ioc_detector_chk.sv
// Property checker for gpio_ioc_detector, attached by bind.
module gpio_ioc_detector_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         pend,
    input logic [W-1:0] irq_en_i,
    input logic         clr_on_cap_i,
    input logic         open_drain_i,
    input logic         rd_port_i,
    input logic         rd_cap_i,
    input logic [W-1:0] flags_o,
    input logic [W-1:0] snap_o,
    input logic         irq_o,
    input logic         irq_oe_o
);
    // R1
    reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!pend && flags_o == '0));

    // R2
    flag_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> ((flags_o & ~$past(irq_en_i)) == '0));

    // R3
    flag_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend == (flags_o != '0));

    // R5
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pend) && pend) |-> ($stable(flags_o) && $stable(snap_o)));

    // R6
    port_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr_on_cap_i && rd_port_i) |=> (flags_o == '0));

    // R7
    snap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && clr_on_cap_i && rd_cap_i && !rd_port_i) |=> !pend);

    // R10
    open_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_drain_i |-> (irq_oe_o == pend && !irq_o));
endmodule

bind gpio_ioc_detector gpio_ioc_detector_chk #(.W(W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pend         (pend),
    .irq_en_i     (irq_en_i),
    .clr_on_cap_i (clr_on_cap_i),
    .open_drain_i (open_drain_i),
    .rd_port_i    (rd_port_i),
    .rd_cap_i     (rd_cap_i),
    .flags_o      (flags_o),
    .snap_o       (snap_o),
    .irq_o        (irq_o),
    .irq_oe_o     (irq_oe_o)
);

// File: tb/gpio_ioc_detector_tb.sv
// Bench: table-driven main sequence, then directed corner tests.
module gpio_ioc_detector_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_i = '0, irq_en_i = '0, cmp_mode_i = '0, ref_val_i = '0;
    logic       clr_on_cap_i = 1'b0, act_high_i = 1'b1, open_drain_i = 1'b0;
    logic       rd_port_i = 1'b0, rd_cap_i = 1'b0;
    logic [7:0] flags_o, snap_o;
    logic       irq_o, irq_oe_o;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    gpio_ioc_detector dut_i (.*);

    // Vector: pin, en, mode, ref, rd_port, exp_pend, exp_flags, exp_snap
    localparam int NV = 13;
    localparam logic [49:0] VEC [NV] = '{
        {8'h00, 8'hFF, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'h00}, // idle
        {8'h01, 8'hFF, 8'h00, 8'h00, 1'b0, 1'b1, 8'h01, 8'h01}, // R3 change
        {8'h03, 8'hFF, 8'h00, 8'h00, 1'b0, 1'b1, 8'h01, 8'h01}, // R5 frozen
        {8'h03, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00, 8'h01}, // R6 clear
        {8'h03, 8'hFF, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'h01}, // R11 no event
        {8'h0C, 8'hFF, 8'h00, 8'h00, 1'b0, 1'b1, 8'h0F, 8'h0C}, // R12 multi
        {8'h0C, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00, 8'h0C}, // R6 clear
        {8'h1C, 8'h0F, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 8'h0C}, // R2 disabled
        {8'h1C, 8'h10, 8'h10, 8'h00, 1'b0, 1'b1, 8'h10, 8'h1C}, // R4 mismatch
        {8'h1C, 8'h10, 8'h10, 8'h00, 1'b1, 1'b0, 8'h00, 8'h1C}, // R8 clear
        {8'h1C, 8'h10, 8'h10, 8'h00, 1'b0, 1'b1, 8'h10, 8'h1C}, // R8 refire
        {8'h0C, 8'h10, 8'h10, 8'h00, 1'b1, 1'b0, 8'h00, 8'h1C}, // R8 clear
        {8'h0C, 8'h10, 8'h10, 8'h00, 1'b0, 1'b0, 8'h00, 8'h1C}  // R4 match
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        @(negedge clk);
        step();
        step();
        // R1 reset state
        chk("R1 flags", {8'h0, flags_o}, 16'h0);
        chk("R1 snap", {8'h0, snap_o}, 16'h0);
        chk("R1 irq", {14'h0, irq_oe_o, irq_o}, 16'h2);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            {pin_i, irq_en_i, cmp_mode_i, ref_val_i, rd_port_i} = VEC[k][49:17];
            step();
            chk($sformatf("vec%0d pend", k), {15'h0, irq_o}, {15'h0, VEC[k][16]});
            chk($sformatf("vec%0d flags", k), {8'h0, flags_o}, {8'h0, VEC[k][15:8]});
            chk($sformatf("vec%0d snap", k), {8'h0, snap_o}, {8'h0, VEC[k][7:0]});
        end
        rd_port_i = 1'b0;

        // Make a change-mode interrupt pending.
        irq_en_i = 8'hFF; cmp_mode_i = 8'h00;
        pin_i = 8'h0D;
        step();
        chk("R3 take", {8'h0, flags_o}, 16'h01);
        // R9 polarity
        act_high_i = 1'b0;
        #1 chk("R9 low active", {14'h0, irq_oe_o, irq_o}, 16'h2);
        // R10 open drain while pending
        open_drain_i = 1'b1;
        #1 chk("R10 pending", {14'h0, irq_oe_o, irq_o}, 16'h2);
        // R6: snapshot read ignored when port read selected
        rd_cap_i = 1'b1;
        step();
        rd_cap_i = 1'b0;
        chk("R6 cap ignored", {8'h0, flags_o}, 16'h01);
        // R7: port read ignored, snapshot read clears
        clr_on_cap_i = 1'b1;
        rd_port_i = 1'b1;
        step();
        rd_port_i = 1'b0;
        chk("R7 port ignored", {8'h0, flags_o}, 16'h01);
        rd_cap_i = 1'b1;
        step();
        rd_cap_i = 1'b0;
        chk("R7 cap clears", {8'h0, flags_o}, 16'h00);
        chk("R10 idle", {14'h0, irq_oe_o, irq_o}, 16'h0);
        open_drain_i = 1'b0;
        #1 chk("R9 idle low active", {14'h0, irq_oe_o, irq_o}, 16'h3);
        act_high_i = 1'b1;

        // R1 mid-run reset while pending, then release with steady pins.
        pin_i = 8'h55;
        step();
        chk("R1 pre", {8'h0, flags_o}, 16'h58);
        rst_n = 1'b0;
        step();
        chk("R1 held", {7'h0, irq_o, flags_o}, 16'h0);
        rst_n = 1'b1;
        step();
        step();
        chk("R1 release", {7'h0, irq_o, flags_o}, 16'h0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule